// File: doc/BRIEF.md
# Mailbox Command Responder

This block is the co-processor end of a host mailbox exchange. The host reaches it through a 32-bit register port. Behind that port sit a control word, a doorbell register running from host to co-processor, a status register running back to the host, and a 16-word message RAM. The host fills the RAM with a command message and rings the doorbell. The block then reads the message and works out its checksum. It checks the header, the layout and the command code. It overwrites the RAM with a reply message that carries a fresh checksum. Only after that does it post a status code to the host-facing register.

Each command code produces a fixed reply, so the block serves as a protocol-accurate stand-in for a co-processor. The host treats the exchange as finished once it writes zero to the release register. Which register that is depends on the protocol version selected by parameter. A new command is accepted only when the status register reads zero again.

Top module: `mbox_responder`

## Requirements
- R1: After reset the control word reads 0x1, meaning hold is set. The doorbell and status registers both read 0.
- R2: Register offsets are: control at 0x000, with bit 0 as hold; doorbell at 0x010; status at 0x014; message word i at 0x100 + 4*i, for i from 0 to 15.
- R3: A write of value 1 to the doorbell, made while hold is clear and no exchange is open, starts processing. A non-zero status follows within 40 cycles.
- R4: The message layout is word 0 header, word 1 command, word 2 argument count N, and arguments from word 3. The checksum is at word N+3 and is the 32-bit wrap-around sum of words 0 to N+2. A valid message gets status 0x00000001.
- R5: Errors are checked in this order, and the first one found sets the status. A header other than 1 gives 0x80000001. Otherwise N > 12 gives 0x80000008. Otherwise a checksum mismatch gives 0x80000004. Otherwise an unknown command gives 0x80000002.
- R6: The accepted codes depend on the protocol version. Version 1 accepts 0x1 and 0x2. Version 2 accepts 0x101, 0x201 and 0x202. Version 3 accepts 0x101 and 0x202. The info code (0x1 in version 1, 0x101 otherwise) replies with N=1 and a single argument equal to INFO_WORD. Any other accepted code replies with N=REPLY_ARGS, where argument k is {cmd[15:0], 8'h00, k[7:0]}. An error reply has N=0.
- R7: Before the status turns non-zero, the reply is complete in RAM. It has header 2, the command echoed in word 1, the reply count in word 2, a correct checksum at word N+3, and zeros in every word after the checksum.
- R8: While hold is set, doorbell writes are ignored and the status stays 0.
- R9: While an exchange is unreleased, three things hold. A doorbell write starts nothing. Host writes to message RAM are dropped. The status keeps its value.
- R10: In version 2 and later, writing 0 to the doorbell releases the exchange and clears the status, and a host write to the status register is ignored. In version 1, writing 0 to the status register releases the exchange, and writing 0 to the doorbell does not.
- R11: The largest legal argument count, 12, is accepted. Its checksum sits in word 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |

## Verification
A wrong index or a bad accumulator shows up at the ports in two ways: the reply checksum does not match, or the wrong error code is posted. Both become visible as soon as the status goes non-zero, about 35 cycles after the doorbell. A control state stuck open or released too early changes when the status register clears, or whether a second doorbell is accepted. The bench reads both of these back through the register port right after each release or ignored write.

// File: rtl/mbox_resp_pkg.sv
package mbox_resp_pkg;
  localparam int MSG_WORDS = 16;
  localparam int IDX_W     = $clog2(MSG_WORDS);
  localparam int MAX_ARGS  = MSG_WORDS - 4;

  localparam logic [31:0] ST_OK      = 32'h0000_0001;
  localparam logic [31:0] ST_BAD_HDR = 32'h8000_0001;
  localparam logic [31:0] ST_BAD_CMD = 32'h8000_0002;
  localparam logic [31:0] ST_BAD_SUM = 32'h8000_0004;
  localparam logic [31:0] ST_MALFORM = 32'h8000_0008;

  typedef enum logic [2:0] {
    W_HDR, W_CMD, W_ARGC, W_INFO, W_GEN, W_CSUM, W_ZERO
  } wsel_e;

  typedef struct packed {
    logic             sumClr;
    logic             sumAdd;
    logic             ramWe;
    logic [IDX_W-1:0] idx;
    wsel_e            wsel;
    logic [31:0]      cmdEcho;
    logic [7:0]       argcOut;
    logic             postStatus;
    logic [31:0]      status;
    logic             armRelease;
    logic             hostRamOpen;
  } ctl_t;

  function automatic logic isInfoCmd(input int ver, input logic [31:0] cmd);
    return (ver < 2) ? (cmd == 32'h1) : (cmd == 32'h101);
  endfunction

  function automatic logic isKnownCmd(input int ver, input logic [31:0] cmd);
    if (ver < 2)       return (cmd == 32'h1) || (cmd == 32'h2);
    else if (ver == 2) return (cmd == 32'h101) || (cmd == 32'h201) || (cmd == 32'h202);
    else               return (cmd == 32'h101) || (cmd == 32'h202);
  endfunction
endpackage

// File: rtl/mbox_resp_ctrl.sv
module mbox_resp_ctrl
  import mbox_resp_pkg::*;
#(
  parameter int PROTO_VER  = 3,
  parameter int REPLY_ARGS = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        doorbellStb,
  input  logic        releaseStb,
  input  logic        holdBit,
  input  logic [31:0] rdWord,
  input  logic [31:0] sumAcc,
  output ctl_t        ctl
);
  localparam logic [7:0] GEN_ARGC = 8'(REPLY_ARGS);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_DECIDE, S_WRITE, S_POST, S_WAIT} state_e;

  state_e           state;
  logic [IDX_W-1:0] idx;
  logic [31:0]      hdrR, cmdR, argcR, csumR, statusR;
  logic [7:0]       respArgc;
  logic [31:0]      statusNext;
  logic             idxLast, inChkRange, atChk;
  logic [IDX_W-1:0] respChk;

  assign idxLast    = (idx == IDX_W'(MSG_WORDS - 1));
  assign inChkRange = (idx < IDX_W'(3)) || ({1'b0, 32'(idx)} < ({1'b0, argcR} + 33'd3));
  assign atChk      = (idx >= IDX_W'(3)) && ({1'b0, 32'(idx)} == ({1'b0, argcR} + 33'd3));
  assign respChk    = IDX_W'(respArgc) + IDX_W'(3);

  always_comb begin
    if (hdrR != 32'h1)                    statusNext = ST_BAD_HDR;
    else if (argcR > 32'(MAX_ARGS))       statusNext = ST_MALFORM;
    else if (csumR != sumAcc)             statusNext = ST_BAD_SUM;
    else if (!isKnownCmd(PROTO_VER, cmdR)) statusNext = ST_BAD_CMD;
    else                                  statusNext = ST_OK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      idx      <= '0;
      hdrR     <= '0;
      cmdR     <= '0;
      argcR    <= '0;
      csumR    <= '0;
      statusR  <= '0;
      respArgc <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (doorbellStb && !holdBit) begin
          state <= S_SCAN;
          idx   <= '0;
        end
        S_SCAN: begin
          if (idx == IDX_W'(0)) hdrR  <= rdWord;
          if (idx == IDX_W'(1)) cmdR  <= rdWord;
          if (idx == IDX_W'(2)) argcR <= rdWord;
          if (atChk)            csumR <= rdWord;
          idx <= idx + 1'b1;
          if (idxLast) state <= S_DECIDE;
        end
        S_DECIDE: begin
          statusR <= statusNext;
          if (statusNext != ST_OK)           respArgc <= 8'd0;
          else if (isInfoCmd(PROTO_VER, cmdR)) respArgc <= 8'd1;
          else                               respArgc <= GEN_ARGC;
          idx   <= '0;
          state <= S_WRITE;
        end
        S_WRITE: begin
          idx <= idx + 1'b1;
          if (idxLast) state <= S_POST;
        end
        S_POST: state <= S_WAIT;
        S_WAIT: if (releaseStb) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl             = '0;
    ctl.idx         = idx;
    ctl.wsel        = W_ZERO;
    ctl.cmdEcho     = cmdR;
    ctl.argcOut     = respArgc;
    ctl.status      = statusR;
    ctl.hostRamOpen = (state == S_IDLE);
    ctl.armRelease  = (state == S_WAIT);
    ctl.postStatus  = (state == S_POST);
    unique case (state)
      S_IDLE:   ctl.sumClr = doorbellStb && !holdBit;
      S_SCAN:   ctl.sumAdd = inChkRange;
      S_DECIDE: ctl.sumClr = 1'b1;
      S_WRITE: begin
        ctl.ramWe  = 1'b1;
        ctl.sumAdd = (idx < respChk);
        if (idx == IDX_W'(0))      ctl.wsel = W_HDR;
        else if (idx == IDX_W'(1)) ctl.wsel = W_CMD;
        else if (idx == IDX_W'(2)) ctl.wsel = W_ARGC;
        else if (idx < respChk)    ctl.wsel = isInfoCmd(PROTO_VER, cmdR) ? W_INFO : W_GEN;
        else if (idx == respChk)   ctl.wsel = W_CSUM;
        else                       ctl.wsel = W_ZERO;
      end
      default: ;
    endcase
  end

  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && !releaseStb) |=> (state == S_WAIT));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && holdBit) |=> (state == S_IDLE));

  // R5
  status_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.postStatus |-> (ctl.status == ST_OK) ||
      (ctl.status[31] && $onehot(ctl.status[30:0]) && ctl.status[30:4] == '0));
endmodule

// File: rtl/mbox_resp_dpath.sv
module mbox_resp_dpath
  import mbox_resp_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          PROTO_VER = 3,
  parameter logic [31:0] INFO_WORD = 32'h0103_0207
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  input  ctl_t              ctl,
  output logic [31:0]       regRdata,
  output logic              doorbellStb,
  output logic              releaseStb,
  output logic              holdBit,
  output logic [31:0]       rdWord,
  output logic [31:0]       sumAcc
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_TOCOP  = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] A_TOHOST = ADDR_W'('h014);
  localparam int                RAM_BASE = 'h100;
  localparam int                RAM_SPAN = MSG_WORDS * 4;

  logic [31:0]      ram [MSG_WORDS];
  logic [31:0]      toCop, toHost, engWdata;
  logic             ramHit, hostRamWe;
  logic [IDX_W-1:0] hostIdx;

  assign ramHit    = (32'(regAddr) >= RAM_BASE) && (32'(regAddr) < RAM_BASE + RAM_SPAN) &&
                     (regAddr[1:0] == 2'b00);
  assign hostIdx   = regAddr[IDX_W+1:2];
  assign hostRamWe = regWe && ramHit && ctl.hostRamOpen;

  assign doorbellStb = regWe && (regAddr == A_TOCOP) && (regWdata == 32'h1);

  generate
    if (PROTO_VER < 2) begin : g_relHost
      assign releaseStb = ctl.armRelease && regWe && (regAddr == A_TOHOST) && (regWdata == '0);
    end else begin : g_relCop
      assign releaseStb = ctl.armRelease && regWe && (regAddr == A_TOCOP) && (regWdata == '0);
    end
  endgenerate

  assign rdWord = ram[ctl.idx];

  always_comb begin
    unique case (ctl.wsel)
      W_HDR:   engWdata = 32'h2;
      W_CMD:   engWdata = ctl.cmdEcho;
      W_ARGC:  engWdata = {24'h0, ctl.argcOut};
      W_INFO:  engWdata = INFO_WORD;
      W_GEN:   engWdata = {ctl.cmdEcho[15:0], 8'h00, 8'(ctl.idx) - 8'd3};
      W_CSUM:  engWdata = sumAcc;
      default: engWdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MSG_WORDS; i++) ram[i] <= '0;
    end else if (ctl.ramWe) begin
      ram[ctl.idx] <= engWdata;
    end else if (hostRamWe) begin
      ram[hostIdx] <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumAcc  <= '0;
      holdBit <= 1'b1;
      toCop   <= '0;
      toHost  <= '0;
    end else begin
      if (ctl.sumClr)      sumAcc <= '0;
      else if (ctl.sumAdd) sumAcc <= sumAcc + (ctl.ramWe ? engWdata : rdWord);
      if (regWe && regAddr == A_CTRL)  holdBit <= regWdata[0];
      if (regWe && regAddr == A_TOCOP) toCop   <= regWdata;
      if (ctl.postStatus)   toHost <= ctl.status;
      else if (releaseStb)  toHost <= '0;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == A_CTRL)        regRdata = {31'h0, holdBit};
    else if (regAddr == A_TOCOP)  regRdata = toCop;
    else if (regAddr == A_TOHOST) regRdata = toHost;
    else if (ramHit)              regRdata = ram[hostIdx];
  end

  logic [31:0]      modelSum;
  logic [IDX_W-1:0] modelPos;
  assign modelPos = ram[2][IDX_W-1:0] + IDX_W'(3);
  always_comb begin
    modelSum = '0;
    for (int i = 0; i < MSG_WORDS; i++)
      if (IDX_W'(i) < modelPos) modelSum = modelSum + ram[i];
  end

  // R9
  status_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toHost != '0) |-> ctl.armRelease);

  // R7
  reply_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toHost != '0) |-> (ram[0] == 32'h2) && (ram[2] <= 32'(MAX_ARGS)) &&
      (ram[modelPos] == modelSum));

  // R9
  ram_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.armRelease && !releaseStb) |=> $stable(ram[0]));
endmodule

// File: rtl/mbox_responder.sv
module mbox_responder
  import mbox_resp_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          PROTO_VER  = 3,
  parameter int          REPLY_ARGS = 6,
  parameter logic [31:0] INFO_WORD  = 32'h0103_0207
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata
);
  ctl_t        ctl;
  logic        doorbellStb, releaseStb, holdBit;
  logic [31:0] rdWord, sumAcc;

  mbox_resp_ctrl #(.PROTO_VER(PROTO_VER), .REPLY_ARGS(REPLY_ARGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .doorbellStb(doorbellStb), .releaseStb(releaseStb),
    .holdBit(holdBit), .rdWord(rdWord), .sumAcc(sumAcc), .ctl(ctl)
  );

  mbox_resp_dpath #(.ADDR_W(ADDR_W), .PROTO_VER(PROTO_VER), .INFO_WORD(INFO_WORD)) u_dpath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .ctl(ctl), .regRdata(regRdata), .doorbellStb(doorbellStb), .releaseStb(releaseStb),
    .holdBit(holdBit), .rdWord(rdWord), .sumAcc(sumAcc)
  );
endmodule

// File: tb/test_mbox_responder.sv
`timescale 1ns/1ps
module test_mbox_responder;
  localparam int          REPLY_ARGS = 6;
  localparam logic [31:0] INFO_WORD  = 32'h0103_0207;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  we = 2'b00;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdV3, rdV1;
  int          dutSel = 0;
  int          checks = 0, errors = 0;
  logic [31:0] msg [16];

  always #4 clk = ~clk;

  mbox_responder #(.PROTO_VER(3), .REPLY_ARGS(REPLY_ARGS), .INFO_WORD(INFO_WORD)) i_mbox_responder (
    .clk(clk), .rstN(rstN), .regWe(we[0]), .regAddr(addr), .regWdata(wdata), .regRdata(rdV3));
  mbox_responder #(.PROTO_VER(1), .REPLY_ARGS(REPLY_ARGS), .INFO_WORD(INFO_WORD)) i_mbox_responder_v1 (
    .clk(clk), .rstN(rstN), .regWe(we[1]), .regAddr(addr), .regWdata(wdata), .regRdata(rdV1));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = (dutSel == 0) ? 2'b01 : 2'b10;
    @(posedge clk);
    #1 we = 2'b00;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = (dutSel == 0) ? rdV3 : rdV1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitStatus(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 40; i++) begin
      rd(12'h014, st);
      if (st != '0) break;
    end
  endtask

  // builds and loads a message; argc > 12 leaves no checksum slot
  task automatic loadMsg(input logic [31:0] hdr, input logic [31:0] cmd,
                         input logic [31:0] argc, input logic [31:0] seed, input logic badSum);
    logic [31:0] s;
    msg[0] = hdr; msg[1] = cmd; msg[2] = argc;
    for (int i = 3; i < 16; i++) msg[i] = seed + 32'(i) * 32'h0101_0101;
    if (argc <= 12) begin
      s = '0;
      for (int i = 0; i < 16; i++) if (32'(i) < argc + 3) s = s + msg[i];
      msg[argc + 3] = badSum ? s + 32'h1 : s;
      for (int i = 0; i < 16; i++) if (32'(i) > argc + 3) msg[i] = '0;
    end
    for (int i = 0; i < 16; i++) wr(12'h100 + 12'(4 * i), msg[i]);
  endtask

  task automatic checkReply(input string tag, input logic [31:0] cmd,
                            input logic [31:0] st, input logic isInfo);
    logic [31:0] n, s, w, e;
    n = (st != 32'h1) ? 32'd0 : (isInfo ? 32'd1 : 32'(REPLY_ARGS));
    s = 32'h2 + cmd + n;
    for (int i = 0; i < 16; i++) begin
      if (i == 0)                    e = 32'h2;
      else if (i == 1)               e = cmd;
      else if (i == 2)               e = n;
      else if (32'(i) < n + 3)       e = isInfo ? INFO_WORD : {cmd[15:0], 8'h00, 8'(i - 3)};
      else if (32'(i) == n + 3)      e = s;
      else                           e = '0;
      if (i >= 3 && 32'(i) < n + 3) s = s + e;
      rd(12'h100 + 12'(4 * i), w);
      check($sformatf("%s R7 reply word %0d", tag, i), w, e);
    end
  endtask

  task automatic releaseV3();
    logic [31:0] st;
    wr(12'h010, 32'h0);
    rd(12'h014, st);
    check("R10 v3 release clears status", st, 32'h0);
  endtask

  task automatic exchangeV3(input string tag, input logic [31:0] hdr, input logic [31:0] cmd,
                            input logic [31:0] argc, input logic [31:0] seed,
                            input logic badSum, input logic [31:0] expSt);
    logic [31:0] st;
    dutSel = 0;
    loadMsg(hdr, cmd, argc, seed, badSum);
    wr(12'h010, 32'h1);
    waitStatus(st);
    check($sformatf("%s status", tag), st, expSt);
    checkReply(tag, cmd, expSt, cmd == 32'h101);
    releaseV3();
  endtask

  task automatic testReset();
    logic [31:0] v;
    dutSel = 0;
    rd(12'h000, v); check("R1 control reset", v, 32'h1);
    rd(12'h010, v); check("R1 doorbell reset", v, 32'h0);
    rd(12'h014, v); check("R1 status reset", v, 32'h0);
  endtask

  task automatic testHold();
    logic [31:0] v;
    dutSel = 0;
    loadMsg(32'h1, 32'h101, 32'h1, 32'h10, 1'b0);
    wr(12'h010, 32'h1);
    idle(60);
    rd(12'h014, v); check("R8 hold ignores doorbell", v, 32'h0);
    rd(12'h100, v); check("R8 RAM untouched under hold", v, 32'h1);
    wr(12'h000, 32'h0);
    rd(12'h000, v); check("R2 control hold cleared", v, 32'h0);
    wr(12'h010, 32'h0);
    dutSel = 1;
    wr(12'h000, 32'h0);
  endtask

  task automatic testBusy();
    logic [31:0] v;
    dutSel = 0;
    loadMsg(32'h1, 32'h101, 32'h1, 32'h5, 1'b0);
    wr(12'h010, 32'h1);
    waitStatus(v);
    check("R3 info status", v, 32'h1);
    wr(12'h010, 32'h1);
    wr(12'h100, 32'hDEAD_BEEF);
    wr(12'h014, 32'h0);
    idle(50);
    rd(12'h014, v); check("R9 status held while open", v, 32'h1);
    rd(12'h100, v); check("R9 host RAM write dropped", v, 32'h2);
    rd(12'h010, v); check("R2 doorbell readback", v, 32'h1);
    releaseV3();
  endtask

  task automatic testV1();
    logic [31:0] st;
    dutSel = 1;
    loadMsg(32'h1, 32'h2, 32'h1, 32'h2, 1'b0);
    wr(12'h010, 32'h1);
    waitStatus(st);
    check("R6 v1 code 2 status", st, 32'h1);
    checkReply("R6 v1 code 2", 32'h2, st, 1'b0);
    wr(12'h010, 32'h0);
    idle(5);
    rd(12'h014, st); check("R10 v1 doorbell zero does not release", st, 32'h1);
    wr(12'h014, 32'h0);
    rd(12'h014, st); check("R10 v1 status write releases", st, 32'h0);
    loadMsg(32'h1, 32'h1, 32'h1, 32'h3, 1'b0);
    wr(12'h010, 32'h1);
    waitStatus(st);
    check("R6 v1 info status", st, 32'h1);
    checkReply("R6 v1 info", 32'h1, st, 1'b1);
    wr(12'h014, 32'h0);
    loadMsg(32'h1, 32'h101, 32'h0, 32'h0, 1'b0);
    wr(12'h010, 32'h1);
    waitStatus(st);
    check("R6 v1 rejects 0x101", st, 32'h8000_0002);
    wr(12'h014, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    testReset();
    testHold();
    testBusy();
    exchangeV3("R4 info",           32'h1, 32'h101, 32'd1,  32'h1111_0000, 1'b0, 32'h1);
    exchangeV3("R6 refresh",        32'h1, 32'h202, 32'd0,  32'h0,         1'b0, 32'h1);
    exchangeV3("R4 wraparound sum", 32'h1, 32'h202, 32'd5,  32'hF000_0000, 1'b0, 32'h1);
    exchangeV3("R11 max args",      32'h1, 32'h101, 32'd12, 32'hFFFF_FF00, 1'b0, 32'h1);
    exchangeV3("R5 bad header",     32'h3, 32'h101, 32'd1,  32'h7,         1'b1, 32'h8000_0001);
    exchangeV3("R5 malformed",      32'h1, 32'h101, 32'd13, 32'h9,         1'b0, 32'h8000_0008);
    exchangeV3("R5 bad checksum",   32'h1, 32'h999, 32'd2,  32'h4,         1'b1, 32'h8000_0004);
    exchangeV3("R6 v3 unknown",     32'h1, 32'h201, 32'd0,  32'h0,         1'b0, 32'h8000_0002);
    testV1();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule